// File: doc/BRIEF.md
# GPIO Interrupt Controller

A memory-mapped general-purpose I/O block for up to 32 pins. Software drives pins through an output-value register gated per pin by a drive-enable register, and reads back the pin levels after a two-stage synchronizer. Every pin can raise an interrupt along two independent paths. The level path compares the live synchronized input against a per-pin polarity and masks the result. The edge path latches a sticky event on a chosen edge direction, which software clears by writing ones.

All pending sources from both paths are ORed into one summary status bit. A single top-level enable bit gates that summary onto a registered interrupt line, so an interrupt handler reads the summary, then the level and event registers, and acknowledges edge events by writing ones back to the event register. The bus is a plain address / write-enable / write-data port with registered read data.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The byte offsets are: 0x00 summary status, 0x04 summary enable (bit 0), 0x40 synchronized input, 0x44 output value, 0x48 drive enable, 0x50 level polarity, 0x54 level enable, 0x58 edge events, 0x5C edge enable, 0x64 edge direction; bit n of each per-pin register belongs to pin n. Read data appears on the clock edge after the address is presented; any other offset reads zero and a write to it changes nothing.
- R2: pin_oe equals the drive-enable register; pin_out bit n equals output-value bit n when drive-enable bit n is 1 and is 0 otherwise.
- R3: The input register at 0x40 shows pin_in after two register stages.
- R4: A pin's level source is pending when its synchronized input differs from its level-polarity bit (1 = active low, 0 = active high) and its level-enable bit is 1.
- R5: An edge-direction bit of 1 latches the pin's event bit on a falling synchronized input, 0 on a rising one; the opposite edge latches nothing, and an event source is pending when both its event bit and edge-enable bit are 1.
- R6: Writing 1 to an event bit clears it; writing 0 leaves it; no write can set an event bit.
- R7: When an edge is detected in the same cycle as a clearing write to that bit, the bit stays 1.
- R8: Summary status bit 0 is 1 exactly when any level or event source is pending; bits 31 to 1 read 0.
- R9: irq is registered and equals summary status bit 0 AND summary enable bit 0 from the previous cycle.
- R10: After reset all writable registers, the event register, read data and irq are zero.
- R11: Bits at or above the configured pin count read 0 in every per-pin register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Driven pin values |
| pin_oe | output | NUM_PINS | Per-pin drive enable |
| irq | output | 1 | Gated summary interrupt |

## Verification
The hardest case to reach from the ports is an edge being detected in exactly the cycle a clearing write lands on the same event bit, because the detection happens three clock edges after the pin moves. The bench changes the pin, waits one idle cycle and presents the clearing write on the next, so the write meets the detection, and then reads the event register to confirm the bit survived. A long random phase of mixed writes, reads and pin changes, checked every cycle against a behavioural model, covers the interplay of polarity, enables and clears.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO interrupt controller: bus widths and the
// register offsets that software decodes. Assumes byte addressing.
package gpio_irq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_SUMMARY = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SUMEN   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DIN     = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_DOUT    = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_DRVEN   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_LVLPOL  = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_LVLEN   = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_EVT     = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_EVTEN   = 8'h5C;
    localparam logic [ADDR_W-1:0] OFS_EVTDIR  = 8'h64;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-stage synchronizer for asynchronous pin levels plus a third register
// holding the previous synchronized value for edge detection.
// Assumes each pin is an independent slow signal (no bus coherency needed).
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    // Shift pins through the two synchronizer stages and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/gpio_edge_events.sv
// Per-pin edge detector and sticky event latch with write-one-to-clear.
// Assumes cur/prev come from consecutive synchronized samples; a detection
// wins over a clear in the same cycle so no event is dropped.
module gpio_edge_events #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] fall_sel,
    input  logic [W-1:0] clr,
    output logic [W-1:0] hit,
    output logic [W-1:0] evt_q
);
    // Pick the watched edge per pin from the direction bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign hit[i] = fall_sel[i] ? (prev[i] & ~cur[i]) : (cur[i] & ~prev[i]);
    end

    // Latch events; clears apply first, new detections override them.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr) | hit;
    end
endmodule

// File: rtl/gpio_pend_combine.sv
// Combines level and edge sources into per-pin pending vectors and one
// summary flag. Purely combinational; assumes registered inputs.
module gpio_pend_combine #(
    parameter int W = 32
) (
    input  logic [W-1:0] level_in,
    input  logic [W-1:0] lvl_pol,
    input  logic [W-1:0] lvl_en,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] evt_en,
    output logic [W-1:0] lvl_pend,
    output logic [W-1:0] edg_pend,
    output logic         any_pend
);
    // Level sources follow the live input; event sources follow the latch.
    always_comb begin
        lvl_pend = (level_in ^ lvl_pol) & lvl_en;
        edg_pend = evt & evt_en;
        any_pend = |(lvl_pend | edg_pend);
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// GPIO controller top: register file, pin drive, synchronized readback and
// interrupt aggregation onto one registered line.
// Assumes 1 <= NUM_PINS <= 32 and a bus that presents one access per cycle.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int W = NUM_PINS;

    logic [W-1:0] dout_q, drven_q, lpol_q, lven_q, edir_q, een_q;
    logic         sum_en;
    logic [W-1:0] in_sync, in_prev, ev_q, ev_hit, ev_clr;
    logic [W-1:0] lvl_pend, edg_pend;
    logic         sum_pend;
    logic [W-1:0] wr_bits;
    logic [DATA_W-1:0] rd_nxt;

    // Zero-extend a per-pin vector to the bus width.
    function automatic logic [DATA_W-1:0] widen(input logic [W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[W-1:0] = v;
        return r;
    endfunction

    assign wr_bits = bus_wdata[W-1:0];
    assign ev_clr  = (bus_we && bus_addr == OFS_EVT) ? wr_bits : '0;

    gpio_in_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_q   (in_sync),
        .prev_q   (in_prev)
    );

    gpio_edge_events #(.W(W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (in_sync),
        .prev     (in_prev),
        .fall_sel (edir_q),
        .clr      (ev_clr),
        .hit      (ev_hit),
        .evt_q    (ev_q)
    );

    gpio_pend_combine #(.W(W)) u_pend (
        .level_in (in_sync),
        .lvl_pol  (lpol_q),
        .lvl_en   (lven_q),
        .evt      (ev_q),
        .evt_en   (een_q),
        .lvl_pend (lvl_pend),
        .edg_pend (edg_pend),
        .any_pend (sum_pend)
    );

    // Configuration register writes; unmapped offsets fall through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            drven_q <= '0;
            lpol_q  <= '0;
            lven_q  <= '0;
            edir_q  <= '0;
            een_q   <= '0;
            sum_en  <= 1'b0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_SUMEN:  sum_en  <= bus_wdata[0];
                OFS_DOUT:   dout_q  <= wr_bits;
                OFS_DRVEN:  drven_q <= wr_bits;
                OFS_LVLPOL: lpol_q  <= wr_bits;
                OFS_LVLEN:  lven_q  <= wr_bits;
                OFS_EVTEN:  een_q   <= wr_bits;
                OFS_EVTDIR: edir_q  <= wr_bits;
                default: ;
            endcase
        end
    end

    // Select read data for the addressed register.
    always_comb begin
        case (bus_addr)
            OFS_SUMMARY: rd_nxt = {{(DATA_W-1){1'b0}}, sum_pend};
            OFS_SUMEN:   rd_nxt = {{(DATA_W-1){1'b0}}, sum_en};
            OFS_DIN:     rd_nxt = widen(in_sync);
            OFS_DOUT:    rd_nxt = widen(dout_q);
            OFS_DRVEN:   rd_nxt = widen(drven_q);
            OFS_LVLPOL:  rd_nxt = widen(lpol_q);
            OFS_LVLEN:   rd_nxt = widen(lven_q);
            OFS_EVT:     rd_nxt = widen(ev_q);
            OFS_EVTEN:   rd_nxt = widen(een_q);
            OFS_EVTDIR:  rd_nxt = widen(edir_q);
            default:     rd_nxt = '0;
        endcase
    end

    // Register read data and the gated interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            irq       <= 1'b0;
        end else begin
            bus_rdata <= rd_nxt;
            irq       <= sum_pend & sum_en;
        end
    end

    assign pin_out = dout_q & drven_q;
    assign pin_oe  = drven_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Assertion checker for gpio_irq_ctrl, attached by bind. Observes the
// event latch, its detect/clear inputs, the summary path and the pin drive.
module gpio_irq_ctrl_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq,
    input logic         sum_pend,
    input logic         sum_en,
    input logic [W-1:0] ev_q,
    input logic [W-1:0] ev_hit,
    input logic [W-1:0] ev_clr,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(sum_pend && sum_en))); // R9

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_q & ~ev_clr) != '0) |=> ((ev_q & $past(ev_q & ~ev_clr)) == $past(ev_q & ~ev_clr))); // R6

    AST_EVT_SET_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_q & ~$past(ev_q) & ~$past(ev_hit)) == '0)); // R5

    AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_hit & ev_clr) != '0) |=> ((ev_q & $past(ev_hit & ev_clr)) == $past(ev_hit & ev_clr))); // R7

    AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0)); // R2
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .sum_pend (sum_pend),
    .sum_en   (sum_en),
    .ev_q     (ev_q),
    .ev_hit   (ev_hit),
    .ev_clr   (ev_clr),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/tb_gpio_irq_ctrl.sv
// Bench for gpio_irq_ctrl with 20 pins: behavioural model compared every
// clock, plus directed reads with literal expectations.
module tb_gpio_irq_ctrl;
    localparam int NP = 20;
    localparam bit [31:0] PM = (32'h1 << NP) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    gpio_irq_ctrl #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Behavioural model state
    bit [31:0] m_dout, m_drv, m_lpol, m_lven, m_edir, m_een, m_evt, m_rd;
    bit        m_sen, m_irq;
    bit [31:0] hist[$];
    bit [7:0]  m_last;

    function automatic string tag_for(input bit [7:0] a);
        case (a)
            8'h00, 8'h04: return "R8";
            8'h40:        return "R3";
            8'h50, 8'h54: return "R4";
            8'h58:        return "R5";
            8'h44, 8'h48, 8'h5C, 8'h64: return "R11";
            default:      return "R1";
        endcase
    endfunction

    always @(posedge clk) begin
        bit [31:0] cur, prv, lvl, edg, det, clr;
        bit stat;
        if (!rst_n) begin
            m_dout = 0; m_drv = 0; m_lpol = 0; m_lven = 0; m_edir = 0;
            m_een = 0; m_evt = 0; m_rd = 0; m_sen = 0; m_irq = 0;
            hist.delete();
            m_last = 8'hFF;
        end else begin
            cur  = (hist.size() > 1) ? hist[1] : 32'h0;
            prv  = (hist.size() > 2) ? hist[2] : 32'h0;
            lvl  = (cur ^ m_lpol) & m_lven;
            edg  = m_evt & m_een;
            stat = ((lvl | edg) & PM) != 0;
            case (bus_addr)
                8'h00: m_rd = {31'b0, stat};
                8'h04: m_rd = {31'b0, m_sen};
                8'h40: m_rd = cur;
                8'h44: m_rd = m_dout;
                8'h48: m_rd = m_drv;
                8'h50: m_rd = m_lpol;
                8'h54: m_rd = m_lven;
                8'h58: m_rd = m_evt;
                8'h5C: m_rd = m_een;
                8'h64: m_rd = m_edir;
                default: m_rd = 0;
            endcase
            m_last = bus_addr;
            m_irq = stat & m_sen;
            det = ((m_edir & ~cur & prv) | (~m_edir & cur & ~prv)) & PM;
            clr = (bus_we && bus_addr == 8'h58) ? bus_wdata : 32'h0;
            m_evt = ((m_evt & ~clr) | det) & PM;
            if (bus_we) begin
                case (bus_addr)
                    8'h04: m_sen  = bus_wdata[0];
                    8'h44: m_dout = bus_wdata & PM;
                    8'h48: m_drv  = bus_wdata & PM;
                    8'h50: m_lpol = bus_wdata & PM;
                    8'h54: m_lven = bus_wdata & PM;
                    8'h5C: m_een  = bus_wdata & PM;
                    8'h64: m_edir = bus_wdata & PM;
                    default: ;
                endcase
            end
            hist.push_front({12'b0, pin_in});
            if (hist.size() > 3) void'(hist.pop_back());
        end
        #1;
        if (!done) begin
            chk(rst_n ? tag_for(m_last) : "R10", bus_rdata, m_rd);
            chk(rst_n ? "R9" : "R10", {31'b0, irq}, {31'b0, m_irq});
            chk("R2", {12'b0, pin_out}, m_dout & m_drv);
            chk("R2", {12'b0, pin_oe}, m_drv);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_we = 1'b0;
        end
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    endtask

    task automatic rd(input bit [7:0] a, output bit [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(posedge clk);
        #1;
        v = bus_rdata;
    endtask

    task automatic setpin(input bit [NP-1:0] v);
        @(negedge clk);
        pin_in = v; bus_we = 1'b0;
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_up();
    end

    bit [7:0] alist[12] = '{8'h00, 8'h04, 8'h40, 8'h44, 8'h48, 8'h50,
                            8'h54, 8'h58, 8'h5C, 8'h64, 8'h08, 8'h4C};

    initial begin
        bit [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values
        rd(8'h00, v); chk("R10", v, 0);
        rd(8'h48, v); chk("R10", v, 0);
        chk("R10", {31'b0, irq}, 0);
        // R2: drive gating
        wr(8'h44, 32'h000A5A5A);
        wr(8'h48, 32'h0000FF0F);
        idle(1);
        chk("R2", {12'b0, pin_out}, 32'h00005A0A);
        // R11: bits above pin count read zero
        wr(8'h44, 32'hFFFFFFFF);
        rd(8'h44, v); chk("R11", v, 32'h000FFFFF);
        // R3: synchronized input readback
        setpin(20'h12345);
        idle(3);
        rd(8'h40, v); chk("R3", v, 32'h00012345);
        // R1: unmapped offsets
        wr(8'h08, 32'hFFFFFFFF);
        rd(8'h08, v); chk("R1", v, 0);
        rd(8'h4C, v); chk("R1", v, 0);
        // clear events raised by the pin change, then R6: writes cannot set
        wr(8'h58, 32'hFFFFFFFF);
        wr(8'h58, 32'hFFFFFFFF);
        rd(8'h58, v); chk("R6", v, 0);
        // R4 / R8 / R9: level path
        setpin(20'h00001);
        idle(3);
        wr(8'h54, 32'h1);
        wr(8'h04, 32'h1);
        idle(2);
        rd(8'h00, v); chk("R8", v, 32'h1);
        chk("R9", {31'b0, irq}, 1);
        wr(8'h50, 32'h1);
        idle(2);
        rd(8'h00, v); chk("R4", v, 0);
        chk("R9", {31'b0, irq}, 0);
        wr(8'h50, 32'h0);
        wr(8'h04, 32'h0);
        idle(2);
        chk("R9", {31'b0, irq}, 0);
        wr(8'h54, 32'h0);
        // R5: falling-edge selection on pin 3
        wr(8'h64, 32'h8);
        wr(8'h58, 32'hFFFFFFFF);
        setpin(20'h00009);
        idle(4);
        wr(8'h58, 32'h1);
        rd(8'h58, v); chk("R5", v, 0);
        setpin(20'h00001);
        idle(4);
        rd(8'h58, v); chk("R5", v, 32'h8);
        // R6: partial clear
        wr(8'h58, 32'h1);
        rd(8'h58, v); chk("R6", v, 32'h8);
        wr(8'h58, 32'h8);
        rd(8'h58, v); chk("R6", v, 0);
        // R7: rising edge on pin 5 meets a clear in the same cycle
        setpin(20'h00021);
        idle(1);
        wr(8'h58, 32'h20);
        rd(8'h58, v); chk("R7", v, 32'h20);
        wr(8'h58, 32'h20);
        rd(8'h58, v); chk("R7", v, 0);
        // random phase, checked each clock by the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            bus_addr  = alist[$urandom_range(0, 11)];
            bus_we    = $urandom_range(0, 1) == 1;
            bus_wdata = $urandom();
            if ($urandom_range(0, 3) == 0) pin_in = NP'($urandom());
        end
        idle(4);
        finish_up();
    end
endmodule